// File: doc/BRIEF.md
# Programmable Asynchronous Bus-Cycle Sequencer

This block drives one read or write access at a time onto an external asynchronous parallel bus for a single chip-select region. A host presents an access on a valid/ready request port: address, write data and a direction flag. The sequencer then plays out the access as a fixed series of phases. The address settles first. Chip enable falls next, followed by a delay before the strobe. The strobe is output enable for a read and write enable for a write. After the strobe come a hold with chip enable still low and a trailing pause. The access result returns on a one-cycle response pulse carrying read data and an error flag.

Each phase length comes from a runtime timing field. A field value N lasts N+1 units, and one unit is 1, 2, 4 or 8 clock periods as the multiplier selects. Strobe width and hold have separate read and write fields. In ready-wait mode the strobe is held past its programmed width until the synchronised ready input is high. The strobe then stays asserted for an extension field before the hold phase. If ready never arrives, the access is abandoned after a fixed limit. A region-enable input lets the host retire accesses immediately without touching the bus.

The request port has back-pressure. `req_ready` is high only while the sequencer is idle. A request transfers on a clock edge where `req_valid` and `req_ready` are both high. `req_valid` with `req_ready` low has no effect. The response side has no back-pressure: `rsp_valid` is a single-cycle pulse, and the host must take it when it appears. The external data bus is split into output, output-enable and input for the pad ring. All bus control outputs are active low and registered.

Top module: `async_bus_seq`

## Requirements
- R1: After an accepted enabled request, the phases run in the order setup (chip enable high), chip-enable-to-strobe delay, strobe, hold, pause. Each phase lasts (field+1)·M clock cycles. `busy` stays high for exactly the sum of the phases.
- R2: The 2-bit multiplier select `cfg_mult` gives M = 1, 2, 4, 8 for the codes 0, 1, 2, 3.
- R3: Reads use `cfg_rd_width` and `cfg_rd_hold`, and writes use `cfg_wr_width` and `cfg_wr_hold`. The field for the other direction has no effect on an access.
- R4: A read returns on `rsp_rdata` the value of `bus_din` present in the last cycle that `bus_oe_n` is low, sampled at the clock edge that releases `bus_oe_n`.
- R5: A write drives `bus_doe` high from setup through hold. `bus_dout` equals the request's write data while `bus_we_n` is low, and `bus_oe_n` stays high for the whole write.
- R6: With `cfg_wait_en` high, after the width phase the strobe stays low until `bus_rdy`, passed through a two-flop synchroniser, is seen high. The strobe then stays low for a further (`cfg_wait_ext`+1)·M cycles. When ready is already high, the ready-wait costs exactly one cycle.
- R7: If the synchronised ready stays low for TIMEOUT (1024) clock cycles in the ready-wait, the strobe is released and the hold and pause phases still run. The response then carries `rsp_err`=1 and zero read data.
- R8: A request accepted while `cfg_enable` is low produces `rsp_valid` in the next cycle with zero data and no error. `busy` stays low and no bus strobe or chip enable is asserted.
- R9: `req_ready` is low while `busy` is high, and `req_valid` during that time starts no access. `bus_addr` is held stable for the whole access.
- R10: After reset the bus control outputs are high, `bus_doe`, `busy` and `rsp_valid` are low, and `req_ready` is high. Each access gives exactly one `rsp_valid` pulse, in the first cycle `busy` is low.
- R11: Timing fields, multiplier and wait mode are captured at acceptance. Changing them during an access does not alter that access.
- R12: A strobe is only ever low while chip enable is low, and `bus_oe_n` and `bus_we_n` are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Sequencer idle, request may transfer |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read data (zero for writes, disabled region, timeout) |
| rsp_err | output | 1 | Ready timeout occurred |
| busy | output | 1 | Access in progress |
| cfg_enable | input | 1 | Region enable |
| cfg_mult | input | 2 | Multiplier select (1x/2x/4x/8x) |
| cfg_addr_setup | input | FIELD_W | Address setup field |
| cfg_ce_to_strobe | input | FIELD_W | Chip-enable-to-strobe field |
| cfg_rd_width | input | FIELD_W | Read strobe width field |
| cfg_wr_width | input | FIELD_W | Write strobe width field |
| cfg_rd_hold | input | FIELD_W | Read hold field |
| cfg_wr_hold | input | FIELD_W | Write hold field |
| cfg_pause | input | FIELD_W | Trailing pause field |
| cfg_wait_en | input | 1 | Ready-wait mode enable |
| cfg_wait_ext | input | FIELD_W | Strobe extension after ready |
| bus_addr | output | ADDR_W | Bus address |
| bus_dout | output | DATA_W | Bus data out |
| bus_doe | output | 1 | Bus data output enable |
| bus_din | input | DATA_W | Bus data in |
| bus_rdy | input | 1 | Asynchronous ready from the device |
| bus_ce_n | output | 1 | Chip enable, active low |
| bus_oe_n | output | 1 | Output enable, active low |
| bus_we_n | output | 1 | Write enable, active low |

## Verification
The hardest behaviour to reach is the read capture edge. Data sampled one cycle early or late looks correct unless the bus data changes across the strobe. The bench model therefore drives the true data only in the final strobe cycle, whose index it predicts from the timing fields, and drives the inverted value in every other strobe cycle. A second hard case is the ready timeout, which needs a strobe held for over a thousand cycles. A directed access holds ready low to reach it. A third is a request that arrives while the sequencer is busy. To reach it, the bench raises `req_valid` with a different address partway through an access and rewrites every timing input at the same time. This shows both that the stray request is ignored and that the captured timing is kept.

// File: rtl/async_bus_pkg.sv
package async_bus_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE    = 3'd0,
    SQ_SETUP   = 3'd1,
    SQ_CEDLY   = 3'd2,
    SQ_STROBE  = 3'd3,
    SQ_WAITRDY = 3'd4,
    SQ_WAITEXT = 3'd5,
    SQ_HOLD    = 3'd6,
    SQ_PAUSE   = 3'd7
  } seq_state_t;

  // chip enable low in these phases
  function automatic logic ce_phase(seq_state_t s);
    return (s == SQ_CEDLY) || (s == SQ_STROBE) || (s == SQ_WAITRDY) ||
           (s == SQ_WAITEXT) || (s == SQ_HOLD);
  endfunction

  // OE or WE low in these phases
  function automatic logic strobe_phase(seq_state_t s);
    return (s == SQ_STROBE) || (s == SQ_WAITRDY) || (s == SQ_WAITEXT);
  endfunction

  // write data driven in these phases
  function automatic logic drive_phase(seq_state_t s);
    return (s != SQ_IDLE) && (s != SQ_PAUSE);
  endfunction

  // phases timed by the phase timer
  function automatic logic timed_phase(seq_state_t s);
    return (s != SQ_IDLE) && (s != SQ_WAITRDY);
  endfunction

endpackage

// File: rtl/async_bus_sync.sv
module async_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d_async;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];

  // R6
  sync_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q_sync) |-> $past(d_async, STAGES));

endmodule

// File: rtl/async_bus_phase_timer.sv
module async_bus_phase_timer #(
  parameter int FIELD_W = 6,
  parameter int MSEL_W  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [FIELD_W-1:0] field,
  input  logic [MSEL_W-1:0]  msel,
  output logic               last
);
  localparam int SUB_W = (1 << MSEL_W) - 1;

  logic [SUB_W-1:0]   sub_q;
  logic [SUB_W-1:0]   sub_max;
  logic [FIELD_W-1:0] unit_q;

  // multiplier minus one: 0, 1, 3, 7 ...
  assign sub_max = SUB_W'({SUB_W{1'b1}} >> (SUB_W - int'(msel)));
  assign last    = run && (sub_q == sub_max) && (unit_q == field);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q  <= '0;
      unit_q <= '0;
    end else if (!run) begin
      sub_q  <= '0;
      unit_q <= '0;
    end else if (sub_q == sub_max) begin
      sub_q  <= '0;
      unit_q <= (unit_q == field) ? '0 : unit_q + 1'b1;
    end else begin
      sub_q <= sub_q + 1'b1;
    end
  end

  // R1
  unit_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (unit_q <= field));

endmodule

// File: rtl/async_bus_wait_guard.sv
module async_bus_wait_guard #(
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  output logic expire
);
  localparam int CNT_W = $clog2(LIMIT);

  logic [CNT_W-1:0] cnt_q;

  assign expire = active && (cnt_q == CNT_W'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (!active) cnt_q <= '0;
    else if (!expire) cnt_q <= cnt_q + 1'b1;
  end

  // R7
  expire_after_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |-> $past(active));

endmodule

// File: rtl/async_bus_seq.sv
module async_bus_seq
  import async_bus_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16,
  parameter int FIELD_W = 6,
  parameter int TIMEOUT = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_rdata,
  output logic               rsp_err,
  output logic               busy,
  input  logic               cfg_enable,
  input  logic [1:0]         cfg_mult,
  input  logic [FIELD_W-1:0] cfg_addr_setup,
  input  logic [FIELD_W-1:0] cfg_ce_to_strobe,
  input  logic [FIELD_W-1:0] cfg_rd_width,
  input  logic [FIELD_W-1:0] cfg_wr_width,
  input  logic [FIELD_W-1:0] cfg_rd_hold,
  input  logic [FIELD_W-1:0] cfg_wr_hold,
  input  logic [FIELD_W-1:0] cfg_pause,
  input  logic               cfg_wait_en,
  input  logic [FIELD_W-1:0] cfg_wait_ext,
  output logic [ADDR_W-1:0]  bus_addr,
  output logic [DATA_W-1:0]  bus_dout,
  output logic               bus_doe,
  input  logic [DATA_W-1:0]  bus_din,
  input  logic               bus_rdy,
  output logic               bus_ce_n,
  output logic               bus_oe_n,
  output logic               bus_we_n
);
  localparam int MSEL_W = 2;

  seq_state_t st_q, st_nxt;

  // timing snapshot taken at acceptance
  logic [FIELD_W-1:0] tm_setup, tm_ce, tm_width, tm_hold, tm_pause, tm_wext;
  logic [MSEL_W-1:0]  tm_msel;
  logic               tm_wait;
  logic               wr_q;

  logic               accept;
  logic               phase_last;
  logic               rdy_s;
  logic               rdy_expire;
  logic               run;
  logic               capture;
  logic [FIELD_W-1:0] phase_field;

  assign req_ready = (st_q == SQ_IDLE);
  assign busy      = (st_q != SQ_IDLE);
  assign accept    = req_valid && req_ready;
  assign run       = timed_phase(st_q);

  async_bus_sync #(.STAGES(SYNC_STAGES)) u_rdy_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (bus_rdy),
    .q_sync  (rdy_s)
  );

  async_bus_phase_timer #(.FIELD_W(FIELD_W), .MSEL_W(MSEL_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (run),
    .field (phase_field),
    .msel  (tm_msel),
    .last  (phase_last)
  );

  async_bus_wait_guard #(.LIMIT(TIMEOUT)) u_guard (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (st_q == SQ_WAITRDY),
    .expire (rdy_expire)
  );

  always_comb begin
    case (st_q)
      SQ_SETUP:   phase_field = tm_setup;
      SQ_CEDLY:   phase_field = tm_ce;
      SQ_STROBE:  phase_field = tm_width;
      SQ_WAITEXT: phase_field = tm_wext;
      SQ_HOLD:    phase_field = tm_hold;
      SQ_PAUSE:   phase_field = tm_pause;
      default:    phase_field = '0;
    endcase
  end

  always_comb begin
    st_nxt = st_q;
    case (st_q)
      SQ_IDLE:    if (accept && cfg_enable) st_nxt = SQ_SETUP;
      SQ_SETUP:   if (phase_last) st_nxt = SQ_CEDLY;
      SQ_CEDLY:   if (phase_last) st_nxt = SQ_STROBE;
      SQ_STROBE:  if (phase_last) st_nxt = tm_wait ? SQ_WAITRDY : SQ_HOLD;
      SQ_WAITRDY: begin
        if (rdy_s)           st_nxt = SQ_WAITEXT;
        else if (rdy_expire) st_nxt = SQ_HOLD;
      end
      SQ_WAITEXT: if (phase_last) st_nxt = SQ_HOLD;
      SQ_HOLD:    if (phase_last) st_nxt = SQ_PAUSE;
      SQ_PAUSE:   if (phase_last) st_nxt = SQ_IDLE;
      default:    st_nxt = SQ_IDLE;
    endcase
  end

  // read data is taken on the edge that releases output enable
  assign capture = !wr_q && phase_last &&
                   (((st_q == SQ_STROBE) && !tm_wait) || (st_q == SQ_WAITEXT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= SQ_IDLE;
      bus_ce_n  <= 1'b1;
      bus_oe_n  <= 1'b1;
      bus_we_n  <= 1'b1;
      bus_doe   <= 1'b0;
      bus_addr  <= '0;
      bus_dout  <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
      wr_q      <= 1'b0;
      tm_setup  <= '0;
      tm_ce     <= '0;
      tm_width  <= '0;
      tm_hold   <= '0;
      tm_pause  <= '0;
      tm_wext   <= '0;
      tm_msel   <= '0;
      tm_wait   <= 1'b0;
    end else begin
      st_q     <= st_nxt;
      bus_ce_n <= !ce_phase(st_nxt);
      bus_oe_n <= !(strobe_phase(st_nxt) && !wr_q);
      bus_we_n <= !(strobe_phase(st_nxt) && wr_q);
      if (st_q == SQ_IDLE) bus_doe <= accept && cfg_enable && req_write;
      else                 bus_doe <= wr_q && drive_phase(st_nxt);

      rsp_valid <= (accept && !cfg_enable) || ((st_q == SQ_PAUSE) && phase_last);

      if (accept) begin
        rsp_rdata <= '0;
        rsp_err   <= 1'b0;
        if (cfg_enable) begin
          bus_addr <= req_addr;
          bus_dout <= req_wdata;
          wr_q     <= req_write;
          tm_setup <= cfg_addr_setup;
          tm_ce    <= cfg_ce_to_strobe;
          tm_width <= req_write ? cfg_wr_width : cfg_rd_width;
          tm_hold  <= req_write ? cfg_wr_hold : cfg_rd_hold;
          tm_pause <= cfg_pause;
          tm_wext  <= cfg_wait_ext;
          tm_msel  <= cfg_mult;
          tm_wait  <= cfg_wait_en;
        end
      end
      if (capture) rsp_rdata <= bus_din;
      if ((st_q == SQ_WAITRDY) && !rdy_s && rdy_expire) rsp_err <= 1'b1;
    end
  end

  // R12
  strobe_needs_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_oe_n || !bus_we_n) |-> !bus_ce_n);

  // R12
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe_n || bus_we_n);

  // R8
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !cfg_enable) |=> (rsp_valid && !busy && bus_ce_n && (rsp_rdata == '0)));

  // R9
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || $stable(bus_addr)));

  // R10
  rsp_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !busy);

  // R6
  wait_holds_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == SQ_WAITRDY) && !rdy_s && !rdy_expire) |=> (!bus_oe_n || !bus_we_n));

endmodule

// File: tb/async_bus_seq_test.sv
module async_bus_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int FW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic req_ready, rsp_valid, rsp_err, busy;
  logic [15:0] rsp_rdata;
  logic cfg_enable = 1'b1, cfg_wait_en = 1'b0;
  logic [1:0] cfg_mult = '0;
  logic [FW-1:0] cfg_addr_setup = '0, cfg_ce_to_strobe = '0, cfg_rd_width = '0,
                 cfg_wr_width = '0, cfg_rd_hold = '0, cfg_wr_hold = '0,
                 cfg_pause = '0, cfg_wait_ext = '0;
  logic [15:0] bus_addr, bus_dout, bus_din;
  logic bus_doe, bus_ce_n, bus_oe_n, bus_we_n;
  logic bus_rdy = 1'b0;

  int checks = 0, failures = 0;
  bit finished = 0;

  // monitor state
  int busy_cnt, pre_cnt, ce_cnt, oe_cnt, we_cnt, doe_cnt, rsp_cnt, extra_busy;
  logic [15:0] seen_addr, seen_dout;
  int exp_strobe_len;

  always #(CLK_PERIOD/2) clk = ~clk;

  async_bus_seq uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .busy(busy),
    .cfg_enable(cfg_enable), .cfg_mult(cfg_mult), .cfg_addr_setup(cfg_addr_setup),
    .cfg_ce_to_strobe(cfg_ce_to_strobe), .cfg_rd_width(cfg_rd_width),
    .cfg_wr_width(cfg_wr_width), .cfg_rd_hold(cfg_rd_hold), .cfg_wr_hold(cfg_wr_hold),
    .cfg_pause(cfg_pause), .cfg_wait_en(cfg_wait_en), .cfg_wait_ext(cfg_wait_ext),
    .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din),
    .bus_rdy(bus_rdy), .bus_ce_n(bus_ce_n), .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n)
  );

  function automatic logic [15:0] dev_model(logic [15:0] a);
    return {a[7:0], a[15:8]} ^ 16'h3C6B;
  endfunction

  // device model and event counters, sampled mid-cycle
  initial bus_din = 16'h0000;
  always @(negedge clk) begin
    if (busy) busy_cnt++;
    if (rsp_cnt > 0 && busy) extra_busy++;
    if (busy && bus_ce_n && ce_cnt == 0) pre_cnt++;
    if (!bus_ce_n) begin ce_cnt++; seen_addr = bus_addr; end
    if (bus_doe) doe_cnt++;
    if (!bus_we_n) begin we_cnt++; seen_dout = bus_dout; end
    if (rsp_valid) rsp_cnt++;
    if (!bus_oe_n) begin
      oe_cnt++;
      bus_din = (oe_cnt == exp_strobe_len) ? dev_model(bus_addr) : ~dev_model(bus_addr);
    end else begin
      bus_din = 16'hA5A5;
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic set_cfg(int a, int c, int rw, int ww, int rh, int wh, int p,
                         int sel, bit wen, int x);
    cfg_addr_setup = FW'(a); cfg_ce_to_strobe = FW'(c);
    cfg_rd_width = FW'(rw); cfg_wr_width = FW'(ww);
    cfg_rd_hold = FW'(rh); cfg_wr_hold = FW'(wh);
    cfg_pause = FW'(p); cfg_mult = 2'(sel);
    cfg_wait_en = wen; cfg_wait_ext = FW'(x);
  endtask

  // one access with expectations from the requirements
  task automatic run_access(bit wr, logic [15:0] addr, logic [15:0] wdata,
                            bit tmo, bit poke);
    int m, w, h, strobe, total, pre, ce, ok_data;
    bit en;
    en = cfg_enable;
    m = 1 << int'(cfg_mult);                                   // R2
    w = wr ? int'(cfg_wr_width) : int'(cfg_rd_width);          // R3
    h = wr ? int'(cfg_wr_hold) : int'(cfg_rd_hold);
    strobe = (w + 1) * m;
    if (cfg_wait_en) strobe += tmo ? 1024 : 1 + (int'(cfg_wait_ext) + 1) * m;
    pre = (int'(cfg_addr_setup) + 1) * m;
    ce = (int'(cfg_ce_to_strobe) + 1 + h + 1) * m + strobe;
    total = pre + ce + (int'(cfg_pause) + 1) * m;
    @(negedge clk);
    busy_cnt = 0; pre_cnt = 0; ce_cnt = 0; oe_cnt = 0; we_cnt = 0;
    doe_cnt = 0; rsp_cnt = 0; extra_busy = 0;
    exp_strobe_len = wr ? -1 : strobe;
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wdata;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      @(negedge clk);
      req_valid = 1'b1; req_addr = ~addr; req_write = ~wr;
      set_cfg(9, 9, 9, 9, 9, 9, 9, 3, ~cfg_wait_en, 9);
      @(negedge clk);
      req_valid = 1'b0;
    end
    while (rsp_cnt == 0) @(negedge clk);
    repeat (4) @(negedge clk);
    check(rsp_cnt == 1, "R10", "response pulses", rsp_cnt, 1);
    check(extra_busy == 0, "R9", "busy after response", extra_busy, 0);
    if (!en) begin
      check(busy_cnt == 0 && ce_cnt == 0 && oe_cnt == 0 && we_cnt == 0,
            "R8", "bus activity when disabled", ce_cnt + busy_cnt, 0);
      check(rsp_rdata == 16'h0 && !rsp_err, "R8", "disabled response", int'(rsp_rdata), 0);
      return;
    end
    check(busy_cnt == total, poke ? "R11" : "R1", "busy cycles", busy_cnt, total);
    check(pre_cnt == pre, "R1", "setup cycles", pre_cnt, pre);
    check(ce_cnt == ce, "R1", "chip enable cycles", ce_cnt, ce);
    check(seen_addr == addr, "R9", "bus address", int'(seen_addr), int'(addr));
    check(rsp_err == tmo, "R7", "error flag", int'(rsp_err), int'(tmo));
    if (wr) begin
      check(we_cnt == strobe && oe_cnt == 0, "R5", "write strobe cycles", we_cnt, strobe);
      check(seen_dout == wdata, "R5", "write data", int'(seen_dout), int'(wdata));
      check(doe_cnt == pre + ce, "R5", "data enable cycles", doe_cnt, pre + ce);
    end else begin
      check(oe_cnt == strobe && we_cnt == 0,
            cfg_wait_en ? "R6" : "R3", "read strobe cycles", oe_cnt, strobe);
      ok_data = tmo ? 0 : int'(dev_model(addr));
      check(int'(rsp_rdata) == ok_data, tmo ? "R7" : "R4", "read data",
            int'(rsp_rdata), ok_data);
      check(doe_cnt == 0, "R5", "no drive on read", doe_cnt, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL R10 watchdog expired: actual 1 expected 0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    busy_cnt = 0; pre_cnt = 0; ce_cnt = 0; oe_cnt = 0; we_cnt = 0;
    doe_cnt = 0; rsp_cnt = 0; extra_busy = 0; exp_strobe_len = -1;
    seen_addr = '0; seen_dout = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(bus_ce_n && bus_oe_n && bus_we_n && !bus_doe, "R10", "bus idle in reset",
          int'({bus_ce_n, bus_oe_n, bus_we_n, bus_doe}), 14);
    check(!busy && !rsp_valid && req_ready, "R10", "handshake in reset",
          int'({busy, rsp_valid, req_ready}), 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 minimal timing read
    set_cfg(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    run_access(0, 16'h1234, 16'h0, 0, 0);
    // R3 distinct read/write fields
    set_cfg(1, 2, 5, 1, 4, 0, 2, 1, 0, 0);
    run_access(1, 16'h0F0F, 16'hBEEF, 0, 0);
    run_access(0, 16'h0F10, 16'h0, 0, 0);
    // R2 largest multiplier
    set_cfg(2, 1, 3, 3, 1, 1, 1, 3, 0, 0);
    run_access(0, 16'hC001, 16'h0, 0, 0);
    run_access(1, 16'hC002, 16'h5AA5, 0, 0);
    // R6 ready-wait with ready already high
    bus_rdy = 1'b1; repeat (3) @(negedge clk);
    set_cfg(0, 1, 2, 2, 1, 1, 0, 1, 1, 3);
    run_access(0, 16'h7777, 16'h0, 0, 0);
    run_access(1, 16'h7778, 16'h1357, 0, 0);
    // R7 ready never arrives
    bus_rdy = 1'b0; repeat (3) @(negedge clk);
    set_cfg(0, 0, 1, 1, 0, 0, 0, 0, 1, 2);
    run_access(0, 16'h4242, 16'h0, 1, 0);
    // R8 disabled region
    cfg_enable = 1'b0;
    run_access(0, 16'h9999, 16'h0, 0, 0);
    run_access(1, 16'h9998, 16'hFFFF, 0, 0);
    cfg_enable = 1'b1;
    // R9 / R11 request and timing changes while busy
    set_cfg(2, 2, 3, 3, 2, 2, 2, 1, 0, 0);
    run_access(0, 16'h2468, 16'h0, 0, 1);
    set_cfg(1, 1, 2, 4, 1, 3, 1, 0, 0, 0);
    run_access(1, 16'h2469, 16'hA1B2, 0, 1);

    // random accesses
    bus_rdy = 1'b1; repeat (3) @(negedge clk);
    for (int i = 0; i < 40; i++) begin
      set_cfg($urandom % 8, $urandom % 8, $urandom % 8, $urandom % 8, $urandom % 8,
              $urandom % 8, $urandom % 8, $urandom % 4, 1'($urandom % 2), $urandom % 8);
      run_access(1'($urandom % 2), 16'($urandom), 16'($urandom), 0, 0);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule